// File: doc/BRIEF.md
# Chainable Serial Configuration Register

This block is a four-wire serial port that loads a 20-bit configuration word and holds it steady while the next word is being shifted. A serial clock moves bits in while chip select is low. The rising edge of chip select copies the whole shift register into a holding register. That holding register drives four 4-bit per-channel phase codes and four channel enables. A power-down flag is raised whenever no channel is enabled.

The bit leaving the far end of the shift register appears on serial data out. Several devices can therefore be chained, with one device's output feeding the next device's input. They share one chip select and one serial clock. The word meant for the device farthest down the chain is sent first.

An active-low asynchronous reset clears both registers. A test input overrides the outputs to all channels on at phase zero, so the block can be used without programming it.

Top module: `cfg_shift_latch`

## Requirements
- R1: On each rising serial clock edge with chip select low, serial in enters bit 0 and every other bit moves up one place. The first bit of a 20-bit word therefore ends in bit 19.
- R2: Serial out is bit 19 of the shift register and changes only on a rising serial clock edge. After 20 clocks it presents the first bit that was sent.
- R3: Serial clock edges while chip select is high leave the shift register unchanged.
- R4: The holding register takes the shift register content on each rising edge of chip select. Shifting in a new word leaves the outputs unchanged until that edge.
- R5: Holding register bits [19:16], [15:12], [11:8] and [7:4] are the phase codes of channels 1 to 4. They appear on `phase_o[3:0]`, `[7:4]`, `[11:8]` and `[15:12]`. Bits 3, 2, 1 and 0 enable channels 1 to 4 and appear on `enable_o[0]` to `enable_o[3]`.
- R6: `pwrdn_o` is 1 exactly when all four enables seen at the outputs are 0. It falls as soon as chip select rises on a word with any enable set, while the serial port keeps working.
- R7: While `rst_ni` is low, both registers are 0 at once, without any clock.
- R8: While `test_i` is 1, `enable_o` is 4'b1111, `phase_o` is all zero and `pwrdn_o` is 0, whatever is held. Releasing `test_i` restores the held outputs.
- R9: Two chained devices given 40 clocks and one chip select rise each hold their own word: the first 20 bits sent go to the second device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous reset, active low, clears both registers |
| sclk_i | input | 1 | Serial clock, rising edge active |
| csn_i | input | 1 | Chip select, active low; its rising edge loads the holding register |
| sdi_i | input | 1 | Serial data in, MSB first |
| test_i | input | 1 | Forces all channels enabled at phase zero |
| sdo_o | output | 1 | Serial data out toward the next device |
| phase_o | output | 16 | Four 4-bit phase codes, channel 1 in the low nibble |
| enable_o | output | 4 | Channel enables, bit 0 for channel 1 |
| pwrdn_o | output | 1 | High when no channel is enabled |

## Verification
A wrong bit in the shift register does not show on the outputs straight away. It shows on serial out once it has moved up to bit 19, which takes at most 20 clocks, or on the phase and enable outputs at the next chip select rise. In a chain, a shift fault in the first device also corrupts the second device's word. A fault in the holding register or the field mapping shows on `phase_o`, `enable_o` and `pwrdn_o` right after the chip select edge. For that reason the bench compares every output after each chip select rise. It also checks serial out halfway through a chained transfer and the held outputs partway through shifting.

// File: rtl/cfg_pkg.sv
`timescale 1ns/1ps
package cfg_pkg;
  localparam int NUM_CH = 4;
  localparam int PH_W   = 4;
  localparam int WORD_W = NUM_CH * PH_W + NUM_CH;
endpackage

// File: rtl/cfg_shift_reg.sv
`timescale 1ns/1ps
module cfg_shift_reg #(
  parameter int W = cfg_pkg::WORD_W
) (
  input  logic         rst_ni,
  input  logic         sclk_i,
  input  logic         csn_i,
  input  logic         sdi_i,
  output logic [W-1:0] sr_o,
  output logic         sdo_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni)     sr_q <= '0;
    else if (!csn_i) sr_q <= {sr_q[W-2:0], sdi_i};
  end

  assign sr_o  = sr_q;
  assign sdo_o = sr_q[W-1];
endmodule

// File: rtl/cfg_hold_latch.sv
`timescale 1ns/1ps
module cfg_hold_latch #(
  parameter int W = cfg_pkg::WORD_W
) (
  input  logic         rst_ni,
  input  logic         csn_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // chip select edge is the load clock
  always_ff @(posedge csn_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/cfg_field_map.sv
`timescale 1ns/1ps
module cfg_field_map #(
  parameter int N  = cfg_pkg::NUM_CH,
  parameter int PW = cfg_pkg::PH_W,
  localparam int W = N * PW + N
) (
  input  logic [W-1:0]    word_i,
  input  logic            test_i,
  output logic [N*PW-1:0] phase_o,
  output logic [N-1:0]    enable_o,
  output logic            pwrdn_o
);
  logic [N*PW-1:0] phase_raw;
  logic [N-1:0]    en_raw;

  for (genvar k = 0; k < N; k++) begin : g_ch
    localparam int HI = W - 1 - k * PW;
    assign phase_raw[k*PW +: PW] = word_i[HI -: PW];
    assign en_raw[k]             = word_i[N-1-k];
  end

  always_comb begin
    if (test_i) begin
      phase_o  = '0;
      enable_o = '1;
    end else begin
      phase_o  = phase_raw;
      enable_o = en_raw;
    end
  end

  assign pwrdn_o = ~|enable_o;
endmodule

// File: rtl/cfg_shift_latch.sv
`timescale 1ns/1ps
module cfg_shift_latch #(
  parameter int N  = cfg_pkg::NUM_CH,
  parameter int PW = cfg_pkg::PH_W,
  localparam int W = N * PW + N
) (
  input  logic            rst_ni,
  input  logic            sclk_i,
  input  logic            csn_i,
  input  logic            sdi_i,
  input  logic            test_i,
  output logic            sdo_o,
  output logic [N*PW-1:0] phase_o,
  output logic [N-1:0]    enable_o,
  output logic            pwrdn_o
);
  logic [W-1:0] sr_q;
  logic [W-1:0] latch_q;

  cfg_shift_reg #(.W(W)) u_shift (
    .rst_ni(rst_ni), .sclk_i(sclk_i), .csn_i(csn_i), .sdi_i(sdi_i),
    .sr_o(sr_q), .sdo_o(sdo_o)
  );

  cfg_hold_latch #(.W(W)) u_hold (
    .rst_ni(rst_ni), .csn_i(csn_i), .d_i(sr_q), .q_o(latch_q)
  );

  cfg_field_map #(.N(N), .PW(PW)) u_map (
    .word_i(latch_q), .test_i(test_i),
    .phase_o(phase_o), .enable_o(enable_o), .pwrdn_o(pwrdn_o)
  );
endmodule

// File: rtl/cfg_shift_latch_chk.sv
`timescale 1ns/1ps
module cfg_shift_latch_chk #(
  parameter int N  = cfg_pkg::NUM_CH,
  parameter int PW = cfg_pkg::PH_W,
  localparam int W = N * PW + N
) (
  input logic            rst_ni,
  input logic            sclk_i,
  input logic            csn_i,
  input logic            sdi_i,
  input logic            test_i,
  input logic            sdo_o,
  input logic [N*PW-1:0] phase_o,
  input logic [N-1:0]    enable_o,
  input logic            pwrdn_o,
  input logic [W-1:0]    sr_q,
  input logic [W-1:0]    latch_q
);
  a_r1_shift_in: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    !csn_i |=> (sr_q[0] == $past(sdi_i)) && (sr_q[W-1:1] == $past(sr_q[W-2:0])));

  a_r2_sdo_next: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    !csn_i |=> sdo_o == $past(sr_q[W-2]));

  a_r3_hold_deselected: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    csn_i |=> $stable(sr_q) && $stable(sdo_o));

  a_r4_latch_capture: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    $rose(csn_i) |-> latch_q == sr_q);

  a_r6_pwrdn: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    pwrdn_o == (enable_o == '0));

  a_r8_test_force: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    test_i |-> (enable_o == '1) && (phase_o == '0) && !pwrdn_o);

  always @(posedge sclk_i) begin
    if (!rst_ni) begin
      a_r7_reset_clear: assert (sr_q == '0 && latch_q == '0 && sdo_o == 1'b0);
    end
  end
endmodule

bind cfg_shift_latch cfg_shift_latch_chk #(.N(N), .PW(PW)) u_chk (
  .rst_ni(rst_ni), .sclk_i(sclk_i), .csn_i(csn_i), .sdi_i(sdi_i),
  .test_i(test_i), .sdo_o(sdo_o), .phase_o(phase_o), .enable_o(enable_o),
  .pwrdn_o(pwrdn_o), .sr_q(sr_q), .latch_q(latch_q)
);

// File: tb/cfg_shift_latch_tb_top.sv
`timescale 1ns/1ps
module cfg_shift_latch_tb_top;
  localparam int N = 4;
  localparam int PW = 4;
  localparam int W = N * PW + N;

  typedef struct {
    string           tag;
    bit              dev;
    logic [N*PW-1:0] ph;
    logic [N-1:0]    en;
    logic            pd;
  } exp_t;

  logic sclk = 1'b0;
  logic rst_n = 1'b0;
  logic csn = 1'b1;
  logic sdi = 1'b0;
  logic test_a = 1'b0;
  logic sdo_a, sdo_b;
  logic [N*PW-1:0] ph_a, ph_b;
  logic [N-1:0] en_a, en_b;
  logic pd_a, pd_b;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  exp_t exp_q[$];
  event chk_ev;
  logic [W-1:0] cur_a = '0;
  logic [W-1:0] cur_b = '0;

  always #10 sclk = ~sclk;

  cfg_shift_latch dut_i (
    .rst_ni(rst_n), .sclk_i(sclk), .csn_i(csn), .sdi_i(sdi), .test_i(test_a),
    .sdo_o(sdo_a), .phase_o(ph_a), .enable_o(en_a), .pwrdn_o(pd_a)
  );

  cfg_shift_latch dut_b (
    .rst_ni(rst_n), .sclk_i(sclk), .csn_i(csn), .sdi_i(sdo_a), .test_i(1'b0),
    .sdo_o(sdo_b), .phase_o(ph_b), .enable_o(en_b), .pwrdn_o(pd_b)
  );

  function automatic exp_t mk(string tag, bit dev, logic [W-1:0] w, bit tst);
    exp_t e;
    e.tag = tag;
    e.dev = dev;
    for (int k = 0; k < N; k++) begin
      e.ph[k*PW +: PW] = tst ? '0 : w[W-1-k*PW -: PW];
      e.en[k]          = tst ? 1'b1 : w[N-1-k];
    end
    e.pd = (e.en == '0);
    return e;
  endfunction

  task automatic bit_check(string tag, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // driver side of the scoreboard
  task automatic expect_both(string tag, bit tst);
    exp_q.push_back(mk(tag, 1'b0, cur_a, tst));
    exp_q.push_back(mk(tag, 1'b1, cur_b, 1'b0));
    -> chk_ev;
    #3;
  endtask

  // monitor side
  initial begin
    forever begin
      @(chk_ev);
      #1;
      while (exp_q.size() > 0) begin
        exp_t e;
        logic [N*PW+N:0] act, exv;
        e = exp_q.pop_front();
        act = e.dev ? {ph_b, en_b, pd_b} : {ph_a, en_a, pd_a};
        exv = {e.ph, e.en, e.pd};
        n_run++;
        if (act !== exv) begin
          n_fail++;
          $display("FAIL %s dev%0d: actual ph=%h en=%b pd=%b expected ph=%h en=%b pd=%b",
                   e.tag, e.dev, act[N*PW+N:N+1], act[N:1], act[0],
                   e.ph, e.en, e.pd);
        end
      end
    end
  end

  // 40-bit chained transfer, far word first (R9)
  task automatic send_chain(logic [W-1:0] far_w, logic [W-1:0] near_w);
    logic [2*W-1:0] s;
    s = {far_w, near_w};
    for (int idx = 0; idx < 2 * W; idx++) begin
      @(negedge sclk);
      if (idx == 0) csn = 1'b0;
      if (idx == W) bit_check("R2 sdo after 20 clocks", sdo_a, s[2*W-1]);
      if (idx == 30) begin
        n_run++;
        if ({ph_a, en_a} !== {mk("", 1'b0, cur_a, 1'b0).ph, mk("", 1'b0, cur_a, 1'b0).en}) begin
          n_fail++;
          $display("FAIL R4 outputs moved mid-shift: actual %h/%b expected word %h",
                   ph_a, en_a, cur_a);
        end
      end
      sdi = s[2*W-1-idx];
    end
    @(negedge sclk);
    bit_check("R9 sdo of second device", sdo_b, s[2*W-1]);
    csn = 1'b1;
    cur_a = near_w;
    cur_b = far_w;
  endtask

  task automatic cs_pulse();
    @(negedge sclk);
    #2 csn = 1'b0;
    #4 csn = 1'b1;
  endtask

  initial begin
    #5;
    expect_both("R7 reset state", 1'b0);
    bit_check("R7 sdo reset", sdo_a, 1'b0);
    @(negedge sclk);
    rst_n = 1'b1;

    send_chain(20'h12345, 20'hA5C3F);
    expect_both("R5 R9 chain word set 1", 1'b0);

    send_chain(20'hFEDC0, 20'h00008);
    expect_both("R6 R9 chain word set 2 pwrdn", 1'b0);

    send_chain(20'h0F0F2, 20'h70001);
    expect_both("R6 R1 wake on enable", 1'b0);

    // R3: clocks with chip select high are ignored
    for (int i = 0; i < 25; i++) begin
      @(negedge sclk);
      sdi = i[0] ^ i[2];
    end
    cs_pulse();
    #2 expect_both("R3 deselected clocks ignored", 1'b0);

    // R8 test mode override and release
    @(negedge sclk);
    test_a = 1'b1;
    #2 expect_both("R8 test mode forced", 1'b1);
    test_a = 1'b0;
    #2 expect_both("R8 test mode released", 1'b0);

    send_chain(20'h00000, 20'h9ABC0);
    expect_both("R6 R5 all enables clear", 1'b0);

    // R7 async reset without a clock edge
    @(negedge sclk);
    #2 rst_n = 1'b0;
    cur_a = '0;
    cur_b = '0;
    #2 expect_both("R7 async clear", 1'b0);
    bit_check("R7 sdo cleared", sdo_a, 1'b0);
    @(negedge sclk);
    rst_n = 1'b1;
    cs_pulse();
    #2 expect_both("R7 shift register cleared", 1'b0);

    #40;
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule